// File: doc/BRIEF.md
# Instruction Cache Next-Line Pointer Table

This block sits beside a set-associative instruction cache and holds one small pointer for every cache line. The pointer names the line that fetch should read next, as a set index together with the way that holds it. While fetch reads a line from the cache, it also reads that line's pointer from this table. It can then steer the next fetch straight from the pointer, with no decode of the fetched bytes and no address adder. When the line is left with no taken branch, the pointer names the sequentially following line. When a taken branch leaves it, the pointer names the line that holds the branch target.

Fetch, refill and training use three independent ports, and all three can be active in the same cycle. When the cache refills a line, its pointer returns to the sequential default: the next index, wrapping at the last set, in way 0. When the back end resolves where a line was actually left, the training port writes the resolved index and way. In that same cycle the port reports whether the stored pointer disagreed, so that fetch can be redirected. A write becomes visible to fetch in the cycle it is presented, because the read port forwards it. The cache's data and tag arrays and any branch direction state are kept elsewhere.

Top module: `nextline_pred`

## Requirements
- R1: After reset, the pointer of every line at index i and way w reads as index (i+1) mod SETS and way 0.
- R2: In every cycle, pred_idx and pred_way give the pointer held for the line selected by {rd_idx, rd_way}, with no clock latency.
- R3: When trn_valid is high, the trained line holds {trn_nxt_idx, trn_nxt_way} from the next cycle onward, unless a refill hits the same line in that cycle.
- R4: A read of a line that is trained in the same cycle returns the value being trained.
- R5: When fill_valid is high, the filled line holds the sequential default from the next cycle onward. A read of that line in the same cycle already returns the default.
- R6: When a refill and a training write hit the same line in one cycle, the refill wins, both for the forwarded read and for the stored value.
- R7: trn_mispredict is high exactly when trn_valid is high and the pointer stored before this cycle's writes differs from {trn_nxt_idx, trn_nxt_way} in index or way.
- R8: A line that is neither filled nor trained keeps its pointer. A cycle with no write leaves every pointer unchanged.
- R9: The sequential default of the last set (index SETS-1) is index 0, way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| rd_idx | input | IW | Set index of the line being fetched |
| rd_way | input | WW | Way of the line being fetched |
| pred_idx | output | IW | Predicted set index of the next line |
| pred_way | output | WW | Predicted way of the next line |
| fill_valid | input | 1 | A line is being refilled this cycle |
| fill_idx | input | IW | Set index of the refilled line |
| fill_way | input | WW | Way of the refilled line |
| trn_valid | input | 1 | A resolved line exit is being trained this cycle |
| trn_idx | input | IW | Set index of the trained line |
| trn_way | input | WW | Way of the trained line |
| trn_nxt_idx | input | IW | Resolved set index of the line fetched next |
| trn_nxt_way | input | WW | Resolved way of the line fetched next |
| trn_mispredict | output | 1 | Stored pointer disagreed with the resolved next line |

## Verification
The hardest situation to reach is a single cycle in which fetch, refill and training all hit the same line. The outcome then depends on both the forwarding priority and the write priority, and the mispredict flag must still be judged against the old value. Uniform random stimulus over 256 lines almost never produces a three-way collision. The random phase therefore draws about half of its line addresses from a pool of four lines, and directed steps also force the exact refill-over-training case, the wrap at the last set and the re-training of a pointer to its existing value.

// File: rtl/nlp_pkg.sv
package nlp_pkg;
  localparam int unsigned NLP_SETS = 128;
  localparam int unsigned NLP_WAYS = 2;

  function automatic int unsigned nlp_wr_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nlp_store.sv
module nlp_store #(
  parameter int unsigned SETS = nlp_pkg::NLP_SETS,
  parameter int unsigned WAYS = nlp_pkg::NLP_WAYS,
  parameter int unsigned IW   = nlp_pkg::nlp_wr_w(SETS),
  parameter int unsigned WW   = nlp_pkg::nlp_wr_w(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fill_en,
  input  logic [IW+WW-1:0]             fill_line,
  input  logic                         trn_en,
  input  logic [IW+WW-1:0]             trn_line,
  input  logic [IW+WW-1:0]             trn_ptr,
  output logic [SETS*WAYS*(IW+WW)-1:0] ptr_q
);
  localparam int unsigned PW = IW + WW;
  localparam int unsigned N  = SETS * WAYS;

  for (genvar e = 0; e < N; e++) begin : g_ent
    localparam int unsigned SET_I = e / WAYS;
    localparam int unsigned NXT_I = (SET_I + 1) % SETS;
    localparam logic [PW-1:0] DFLT = {IW'(NXT_I), {WW{1'b0}}};

    logic          fill_hit, trn_hit, ent_en;
    logic [PW-1:0] ent_d, ent_q;

    always_comb begin
      fill_hit = fill_en && (fill_line == PW'(e));
      trn_hit  = trn_en  && (trn_line  == PW'(e));
      ent_en   = fill_hit || trn_hit;
      ent_d    = fill_hit ? DFLT : trn_ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= DFLT;
      else if (ent_en) ent_q <= ent_d;
    end

    assign ptr_q[e*PW +: PW] = ent_q;
  end
endmodule

// File: rtl/nlp_rdport.sv
module nlp_rdport #(
  parameter int unsigned SETS = nlp_pkg::NLP_SETS,
  parameter int unsigned WAYS = nlp_pkg::NLP_WAYS,
  parameter int unsigned IW   = nlp_pkg::nlp_wr_w(SETS),
  parameter int unsigned WW   = nlp_pkg::nlp_wr_w(WAYS)
) (
  input  logic [SETS*WAYS*(IW+WW)-1:0] ptr_q,
  input  logic [IW+WW-1:0]             rd_line,
  input  logic                         fill_en,
  input  logic [IW+WW-1:0]             fill_line,
  input  logic                         trn_en,
  input  logic [IW+WW-1:0]             trn_line,
  input  logic [IW+WW-1:0]             trn_ptr,
  output logic [IW+WW-1:0]             rd_ptr
);
  localparam int unsigned PW = IW + WW;

  logic [IW-1:0] rd_set, seq_set;
  logic [PW-1:0] held;

  always_comb begin
    rd_set  = rd_line[PW-1:WW];
    seq_set = (32'(rd_set) == SETS - 1) ? '0 : rd_set + IW'(1);
    held    = ptr_q[rd_line*PW +: PW];
    if (fill_en && fill_line == rd_line)     rd_ptr = {seq_set, {WW{1'b0}}};
    else if (trn_en && trn_line == rd_line)  rd_ptr = trn_ptr;
    else                                     rd_ptr = held;
  end
endmodule

// File: rtl/nlp_verify.sv
module nlp_verify #(
  parameter int unsigned SETS = nlp_pkg::NLP_SETS,
  parameter int unsigned WAYS = nlp_pkg::NLP_WAYS,
  parameter int unsigned IW   = nlp_pkg::nlp_wr_w(SETS),
  parameter int unsigned WW   = nlp_pkg::nlp_wr_w(WAYS)
) (
  input  logic [SETS*WAYS*(IW+WW)-1:0] ptr_q,
  input  logic                         trn_en,
  input  logic [IW+WW-1:0]             trn_line,
  input  logic [IW+WW-1:0]             trn_ptr,
  output logic                         mispredict
);
  localparam int unsigned PW = IW + WW;

  logic [PW-1:0] old_ptr;

  always_comb begin
    old_ptr    = ptr_q[trn_line*PW +: PW];
    mispredict = trn_en && (old_ptr != trn_ptr);
  end
endmodule

// File: rtl/nextline_pred.sv
module nextline_pred #(
  parameter int unsigned SETS = nlp_pkg::NLP_SETS,
  parameter int unsigned WAYS = nlp_pkg::NLP_WAYS,
  parameter int unsigned IW   = nlp_pkg::nlp_wr_w(SETS),
  parameter int unsigned WW   = nlp_pkg::nlp_wr_w(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  input  logic [WW-1:0] rd_way,
  output logic [IW-1:0] pred_idx,
  output logic [WW-1:0] pred_way,
  input  logic          fill_valid,
  input  logic [IW-1:0] fill_idx,
  input  logic [WW-1:0] fill_way,
  input  logic          trn_valid,
  input  logic [IW-1:0] trn_idx,
  input  logic [WW-1:0] trn_way,
  input  logic [IW-1:0] trn_nxt_idx,
  input  logic [WW-1:0] trn_nxt_way,
  output logic          trn_mispredict
);
  localparam int unsigned PW = IW + WW;
  localparam int unsigned N  = SETS * WAYS;

  logic [PW-1:0]   rd_line, fill_line, trn_line, trn_ptr, rd_ptr;
  logic [N*PW-1:0] ptr_q;

  always_comb begin
    rd_line   = {rd_idx, rd_way};
    fill_line = {fill_idx, fill_way};
    trn_line  = {trn_idx, trn_way};
    trn_ptr   = {trn_nxt_idx, trn_nxt_way};
  end

  nlp_store #(.SETS(SETS), .WAYS(WAYS), .IW(IW), .WW(WW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_valid), .fill_line(fill_line),
    .trn_en(trn_valid), .trn_line(trn_line), .trn_ptr(trn_ptr),
    .ptr_q(ptr_q)
  );

  nlp_rdport #(.SETS(SETS), .WAYS(WAYS), .IW(IW), .WW(WW)) u_rd (
    .ptr_q(ptr_q), .rd_line(rd_line),
    .fill_en(fill_valid), .fill_line(fill_line),
    .trn_en(trn_valid), .trn_line(trn_line), .trn_ptr(trn_ptr),
    .rd_ptr(rd_ptr)
  );

  nlp_verify #(.SETS(SETS), .WAYS(WAYS), .IW(IW), .WW(WW)) u_ver (
    .ptr_q(ptr_q), .trn_en(trn_valid), .trn_line(trn_line),
    .trn_ptr(trn_ptr), .mispredict(trn_mispredict)
  );

  assign pred_idx = rd_ptr[PW-1:WW];
  assign pred_way = rd_ptr[WW-1:0];
endmodule

// File: rtl/nlp_chk.sv
module nlp_chk #(
  parameter int unsigned SETS = nlp_pkg::NLP_SETS,
  parameter int unsigned WAYS = nlp_pkg::NLP_WAYS,
  parameter int unsigned IW   = nlp_pkg::nlp_wr_w(SETS),
  parameter int unsigned WW   = nlp_pkg::nlp_wr_w(WAYS)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [IW-1:0]                rd_idx,
  input logic [WW-1:0]                rd_way,
  input logic [IW-1:0]                pred_idx,
  input logic [WW-1:0]                pred_way,
  input logic                         fill_valid,
  input logic [IW-1:0]                fill_idx,
  input logic [WW-1:0]                fill_way,
  input logic                         trn_valid,
  input logic [IW-1:0]                trn_idx,
  input logic [WW-1:0]                trn_way,
  input logic [IW-1:0]                trn_nxt_idx,
  input logic [WW-1:0]                trn_nxt_way,
  input logic                         trn_mispredict,
  input logic [SETS*WAYS*(IW+WW)-1:0] ptr_q
);
  localparam int unsigned PW = IW + WW;

  logic [PW-1:0] c_fill, c_trn, c_rd, c_nxt, c_pred;
  logic          trn_pend, fill_pend;
  logic [PW-1:0] trn_ln_q, trn_ptr_q, fill_ln_q;
  logic [IW-1:0] fill_seq;
  logic [IW-1:0] rd_seq;

  always_comb begin
    c_fill   = {fill_idx, fill_way};
    c_trn    = {trn_idx, trn_way};
    c_rd     = {rd_idx, rd_way};
    c_nxt    = {trn_nxt_idx, trn_nxt_way};
    c_pred   = {pred_idx, pred_way};
    fill_seq = (32'(fill_ln_q[PW-1:WW]) == SETS - 1) ? '0 : fill_ln_q[PW-1:WW] + IW'(1);
    rd_seq   = (32'(rd_idx) == SETS - 1) ? '0 : rd_idx + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trn_pend  <= 1'b0;
      fill_pend <= 1'b0;
      trn_ln_q  <= '0;
      trn_ptr_q <= '0;
      fill_ln_q <= '0;
    end else begin
      trn_pend  <= trn_valid && !(fill_valid && c_fill == c_trn);
      fill_pend <= fill_valid;
      trn_ln_q  <= c_trn;
      trn_ptr_q <= c_nxt;
      fill_ln_q <= c_fill;
    end
  end

  a_r3_train_commit: assert property (@(posedge clk) disable iff (!rst_n)
    trn_pend |-> ptr_q[trn_ln_q*PW +: PW] == trn_ptr_q);

  a_r5_fill_default: assert property (@(posedge clk) disable iff (!rst_n)
    fill_pend |-> ptr_q[fill_ln_q*PW +: PW] == {fill_seq, {WW{1'b0}}});

  a_r4_forward_train: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_valid && c_rd == c_trn && !(fill_valid && c_fill == c_rd)) |-> c_pred == c_nxt);

  a_r6_fill_beats_train: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && c_fill == c_rd) |-> c_pred == {rd_seq, {WW{1'b0}}});

  a_r7_flag_needs_train: assert property (@(posedge clk) disable iff (!rst_n)
    !trn_valid |-> !trn_mispredict);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!trn_valid && !fill_valid) |=> $stable(ptr_q));
endmodule

bind nextline_pred nlp_chk #(.SETS(SETS), .WAYS(WAYS), .IW(IW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_way(rd_way),
  .pred_idx(pred_idx), .pred_way(pred_way),
  .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_way(fill_way),
  .trn_valid(trn_valid), .trn_idx(trn_idx), .trn_way(trn_way),
  .trn_nxt_idx(trn_nxt_idx), .trn_nxt_way(trn_nxt_way),
  .trn_mispredict(trn_mispredict), .ptr_q(ptr_q)
);

// File: tb/sim_nextline_pred.sv
`timescale 1ns/1ps
module sim_nextline_pred;
  logic       clk, rst_n;
  logic [6:0] rd_idx, fill_idx, trn_idx, trn_nxt_idx, pred_idx;
  logic       rd_way, fill_way, trn_way, trn_nxt_way, pred_way;
  logic       fill_valid, trn_valid, trn_mispredict;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [7:0] mdl [0:255];

  nextline_pred u0 (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_way(rd_way),
    .pred_idx(pred_idx), .pred_way(pred_way),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_way(fill_way),
    .trn_valid(trn_valid), .trn_idx(trn_idx), .trn_way(trn_way),
    .trn_nxt_idx(trn_nxt_idx), .trn_nxt_way(trn_nxt_way),
    .trn_mispredict(trn_mispredict)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // sequential default: next index (wrapping at 127), way 0
  function automatic logic [7:0] seq_dflt(input int line);
    return {7'(((line >> 1) + 1) % 128), 1'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, update model at posedge
  task automatic step(input bit fv, input int fl, input bit tv, input int tl,
                      input logic [7:0] tn, input int rl, input string tag);
    logic [7:0] ep;
    logic       em;
    @(negedge clk);
    fill_valid = fv; {fill_idx, fill_way} = 8'(fl);
    trn_valid  = tv; {trn_idx, trn_way}   = 8'(tl);
    {trn_nxt_idx, trn_nxt_way} = tn;
    {rd_idx, rd_way} = 8'(rl);
    #1;
    if (fv && rl == fl)      ep = seq_dflt(rl);
    else if (tv && rl == tl) ep = tn;
    else                     ep = mdl[rl];
    em = tv && (mdl[tl] != tn);
    check({tag, " pred"}, 32'({pred_idx, pred_way}), 32'(ep));
    check({tag, " R7 mispredict"}, 32'(trn_mispredict), 32'(em));
    @(posedge clk);
    if (tv) mdl[tl] = tn;
    if (fv) mdl[fl] = seq_dflt(fl);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = seq_dflt(i);
    rst_n = 0; fill_valid = 0; trn_valid = 0;
    fill_idx = 0; fill_way = 0; trn_idx = 0; trn_way = 0;
    trn_nxt_idx = 0; trn_nxt_way = 0; rd_idx = 0; rd_way = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 / R2: all reset defaults through the read port
    for (int l = 0; l < 256; l++) begin
      @(negedge clk); {rd_idx, rd_way} = 8'(l); #1;
      check("R1 R2 reset pointer", 32'({pred_idx, pred_way}), 32'(seq_dflt(l)));
    end
    // R9: last set wraps to index 0 way 0
    @(negedge clk); {rd_idx, rd_way} = {7'd127, 1'b1}; #1;
    check("R9 wrap", 32'({pred_idx, pred_way}), 32'h0);

    // R4 + R7: train (5,1) -> (40,1), same-cycle read forwarded, mispredict vs default
    step(0, 0, 1, 11, {7'd40, 1'b1}, 11, "R4 forward");
    // R3: stored from the next cycle
    step(0, 0, 0, 0, 8'h0, 11, "R3 stored");
    // R7: same value again -> no mispredict
    step(0, 0, 1, 11, {7'd40, 1'b1}, 11, "R7 agree");
    // R8: neighbour way untouched
    step(0, 0, 0, 0, 8'h0, 10, "R8 neighbour");
    // R6: fill and train collide on (5,1): fill wins
    step(1, 11, 1, 11, {7'd9, 1'b1}, 11, "R6 collide");
    step(0, 0, 0, 0, 8'h0, 11, "R6 stored");
    // R9 / R5: train 127 then refill it
    step(0, 0, 1, 254, {7'd3, 1'b1}, 254, "R3 last set");
    step(1, 254, 0, 0, 8'h0, 254, "R5 R9 refill");
    step(0, 0, 0, 0, 8'h0, 254, "R5 R9 stored");

    // random phase with a narrow hot pool to force collisions
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 4000; k++) begin
      int fl, tl, rl;
      bit fv, tv;
      fv = ($urandom % 4) == 0;
      tv = ($urandom % 2) == 0;
      fl = ($urandom % 2) ? int'($urandom % 4) : int'($urandom % 256);
      tl = ($urandom % 2) ? int'($urandom % 4) : int'($urandom % 256);
      rl = ($urandom % 2) ? int'($urandom % 4) : int'($urandom % 256);
      step(fv, fl, tv, tl, 8'($urandom), rl, "R2 R3 R4 R5 R6 R8 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule